// File: doc/BRIEF.md
# Video-Line Packet Buffer with Auto-Advancing Read Port

This block holds packets captured from video lines until a host collects them. Storage is 2024 bytes split into rows of 44 bytes. Row 0 is kept for control data and is never written. The 45 rows after it form a ring of packet slots. A packet is 44 bytes: two information bytes first (line, field and data type, as the writer supplies them), then 42 payload bytes. For a teletext line, the 42 payload bytes are two address bytes followed by 40 data bytes.

The writer sends a packet as a run of bytes on `wr_en`, with `wr_sop` marking the first byte. The host reads through one 8-bit port. `rd_data` always shows the byte at the read position, and each `rd_strobe` moves that position on by one. Three commands move the read position by whole packets:
- restart the whole buffer,
- rewind to the start of the current packet,
- skip to the next packet.

`pkt_count` gives the number of complete packets that have not yet been consumed.

Top module: `vbi_pkt_buffer`

## Requirements
- R1: After reset, `pkt_count` is 0, `overflow` is 0, and the read position is byte 0 of the first packet row. The first packet written can therefore be read without any command.
- R2: A packet is 44 consecutive accepted bytes, starting with a byte that has `wr_sop`=1. `pkt_count` rises by one at the clock edge that takes the 44th byte.
- R3: `rd_data` shows the stored byte at the read position. Each `rd_strobe` moves to the next byte. Bytes come out in the order they were written: info bytes at positions 0 and 1, payload at positions 2 to 43.
- R4: Packet rows are used in ring order, wrapping after the 45th row, for both writing and reading. No write ever lands in the control row (addresses 0 to 43). `pkt_count` never exceeds 45.
- R5: `cmd_rewind` returns the read position to byte 0 of the same packet and leaves `pkt_count` unchanged.
- R6: When `pkt_count`>0, `cmd_next` moves to byte 0 of the next row and lowers `pkt_count` by one. When `pkt_count` is 0, it only returns to byte 0 and the row stays.
- R7: An `rd_strobe` on byte 43 acts exactly like `cmd_next`.
- R8: A `wr_sop` that arrives while `pkt_count` is 45 drops that whole packet. The stored rows and `pkt_count` stay unchanged, and `overflow` becomes 1 and stays 1.
- R9: `cmd_restart` puts both the read and write positions at the first packet row. It clears `pkt_count` and `overflow` and abandons any partly written packet. Bytes without `wr_sop` are ignored until the next `wr_sop`, and so is any byte presented in the same cycle as the restart.
- R10: A `wr_sop` in the middle of a packet abandons the partial packet. The new packet is written from byte 0 of the same row.
- R11: When commands coincide, priority is restart, then next, then rewind, then `rd_strobe`. A packet completing in the same cycle as a consume leaves `pkt_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write byte valid |
| wr_sop | input | 1 | Marks the first byte of a packet |
| wr_data | input | 8 | Write byte |
| rd_strobe | input | 1 | Consume the byte at the read position and step on |
| cmd_rewind | input | 1 | Return to the start of the current packet |
| cmd_next | input | 1 | Skip to the start of the next packet |
| cmd_restart | input | 1 | Reset the buffer to its first packet row |
| rd_data | output | 8 | Byte at the read position |
| pkt_count | output | 6 | Complete packets not yet consumed |
| overflow | output | 1 | Sticky flag: a packet was dropped because the buffer was full |

## Verification
The writer completing a packet and the reader consuming one can land on the same edge. The bench provokes this by issuing `cmd_next` together with the 44th byte of a new packet. It then judges that `pkt_count` is unchanged and that `rd_data` shows the following packet. Clashes among the read commands are judged the same way. The bench also applies a restart on the last byte of a packet and checks that the commit is lost. It fills all 45 rows, offers one more packet, and reads everything back to confirm that order, wrap and the dropped packet are all correct.

// File: rtl/pkbuf_pkg.sv
// Shared types for the video-line packet buffer.
package pkbuf_pkg;
    // Read-side operation after priority decoding (restart > next > rewind > step).
    typedef enum logic [2:0] {
        RD_HOLD,
        RD_STEP,
        RD_REWIND,
        RD_NEXT,
        RD_RESTART
    } rd_op_e;
endpackage

// File: rtl/pkbuf_mem.sv
// Byte storage for the control row plus the packet rows.
// Assumes: one write port and one asynchronous read port; contents are not reset.
module pkbuf_mem #(
    parameter int DEPTH    = 2024,
    parameter int RESERVED = 44,
    localparam int ADDR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    logic [7:0] store [DEPTH];

    // Store one byte per enabled cycle.
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Present the addressed byte combinationally.
    assign rdata = store[raddr];

    // R4
    ctrl_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (32'(waddr) >= RESERVED));
endmodule

// File: rtl/pkbuf_wr_alloc.sv
// Write-row allocator. It places each packet in the current ring row and
// commits the row after the last byte. A packet that starts while the ring
// is full is dropped whole.
// Assumes: one packet in flight at a time; full comes from the registered count.
module pkbuf_wr_alloc #(
    parameter int ROW_BYTES = 44,
    parameter int PKT_ROWS  = 45,
    localparam int COL_W    = $clog2(ROW_BYTES),
    localparam int ROW_W    = $clog2(PKT_ROWS),
    localparam int ADDR_W   = $clog2((PKT_ROWS + 1) * ROW_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              wr_en,
    input  logic              wr_sop,
    input  logic [7:0]        wr_data,
    input  logic              full,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic              commit,
    output logic              drop_start
);
    logic             active, dropping;
    logic [COL_W-1:0] col, idx_now;
    logic [ROW_W-1:0] row;
    logic             take, start, last;

    // Decide whether this cycle's byte is taken, stored or dropped.
    always_comb begin
        start      = wr_en && !restart && wr_sop;
        take       = wr_en && !restart && (wr_sop || active);
        idx_now    = wr_sop ? '0 : col;
        last       = take && (32'(idx_now) == ROW_BYTES - 1);
        mem_we     = take && !(start ? full : dropping);
        commit     = mem_we && last;
        drop_start = start && full;
        mem_waddr  = ADDR_W'((32'(row) + 32'd1) * 32'(ROW_BYTES) + 32'(idx_now));
        mem_wdata  = wr_data;
    end

    // Track the byte position, the drop state and the write row.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            active   <= 1'b0;
            dropping <= 1'b0;
            col      <= '0;
            row      <= '0;
        end else if (take) begin
            if (last) begin
                active   <= 1'b0;
                dropping <= 1'b0;
                col      <= '0;
                if (commit)
                    row <= (32'(row) == PKT_ROWS - 1) ? '0 : row + ROW_W'(1);
            end else begin
                active   <= 1'b1;
                dropping <= start ? full : dropping;
                col      <= idx_now + COL_W'(1);
            end
        end
    end

    // R10
    sop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sop && !restart) |-> (32'(mem_waddr) % ROW_BYTES == 0));
endmodule

// File: rtl/pkbuf_rd_ptr.sv
// Host read pointer. It holds a row within the ring and a byte column, steps
// on each strobe, and moves by whole packets on command.
// Assumes: op is already priority-decoded; have_pkt is the registered count being non-zero.
module pkbuf_rd_ptr
    import pkbuf_pkg::*;
#(
    parameter int ROW_BYTES = 44,
    parameter int PKT_ROWS  = 45,
    localparam int COL_W    = $clog2(ROW_BYTES),
    localparam int ROW_W    = $clog2(PKT_ROWS),
    localparam int ADDR_W   = $clog2((PKT_ROWS + 1) * ROW_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rd_op_e            op,
    input  logic              have_pkt,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              consume
);
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic             adv;

    // A next command, or a step off the final byte, leaves the packet.
    always_comb begin
        adv     = (op == RD_NEXT) || (op == RD_STEP && 32'(col) == ROW_BYTES - 1);
        consume = adv && have_pkt;
        rd_addr = ADDR_W'((32'(row) + 32'd1) * 32'(ROW_BYTES) + 32'(col));
    end

    // Update the row and column according to the operation.
    always_ff @(posedge clk) begin
        if (!rst_n || op == RD_RESTART) begin
            row <= '0;
            col <= '0;
        end else if (adv) begin
            col <= '0;
            if (have_pkt)
                row <= (32'(row) == PKT_ROWS - 1) ? '0 : row + ROW_W'(1);
        end else if (op == RD_REWIND) begin
            col <= '0;
        end else if (op == RD_STEP) begin
            col <= col + COL_W'(1);
        end
    end

    // R5
    rewind_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == RD_REWIND) |=> (col == '0));
    // R6
    empty_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == RD_NEXT && !have_pkt) |=> (row == $past(row)));
endmodule

// File: rtl/vbi_pkt_buffer.sv
// Top of the packet buffer. It decodes read priority, keeps the count of
// unconsumed packets and the sticky overflow flag, and joins the allocator,
// the read pointer and the storage.
// Assumes: synchronous active-low reset; commands are single-cycle pulses.
module vbi_pkt_buffer
    import pkbuf_pkg::*;
#(
    parameter int ROW_BYTES = 44,
    parameter int PKT_ROWS  = 45,
    localparam int CNT_W    = $clog2(PKT_ROWS + 1),
    localparam int DEPTH    = (PKT_ROWS + 1) * ROW_BYTES,
    localparam int ADDR_W   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sop,
    input  logic [7:0]       wr_data,
    input  logic             rd_strobe,
    input  logic             cmd_rewind,
    input  logic             cmd_next,
    input  logic             cmd_restart,
    output logic [7:0]       rd_data,
    output logic [CNT_W-1:0] pkt_count,
    output logic             overflow
);
    rd_op_e            op;
    logic              full, commit, consume, drop_start, mem_we;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [7:0]        wdata;

    // Resolve clashing read requests into one operation.
    always_comb begin
        if (cmd_restart)     op = RD_RESTART;
        else if (cmd_next)   op = RD_NEXT;
        else if (cmd_rewind) op = RD_REWIND;
        else if (rd_strobe)  op = RD_STEP;
        else                 op = RD_HOLD;
        full = (32'(pkt_count) == PKT_ROWS);
    end

    pkbuf_wr_alloc #(.ROW_BYTES(ROW_BYTES), .PKT_ROWS(PKT_ROWS)) u_wr (
        .clk(clk), .rst_n(rst_n), .restart(cmd_restart),
        .wr_en(wr_en), .wr_sop(wr_sop), .wr_data(wr_data), .full(full),
        .mem_we(mem_we), .mem_waddr(waddr), .mem_wdata(wdata),
        .commit(commit), .drop_start(drop_start)
    );

    pkbuf_rd_ptr #(.ROW_BYTES(ROW_BYTES), .PKT_ROWS(PKT_ROWS)) u_rd (
        .clk(clk), .rst_n(rst_n), .op(op), .have_pkt(pkt_count != '0),
        .rd_addr(raddr), .consume(consume)
    );

    pkbuf_mem #(.DEPTH(DEPTH), .RESERVED(ROW_BYTES)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rd_data)
    );

    // Count complete packets awaiting consumption.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_restart) pkt_count <= '0;
        else pkt_count <= pkt_count + CNT_W'(commit) - CNT_W'(consume);
    end

    // Hold the overflow flag once a packet has been dropped.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_restart) overflow <= 1'b0;
        else if (drop_start)       overflow <= 1'b1;
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pkt_count) <= PKT_ROWS);
    // R8
    full_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !commit);
    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !cmd_restart) |=> overflow);
    // R2
    commit_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !consume && !cmd_restart) |=> (pkt_count == $past(pkt_count) + CNT_W'(1)));
    // R11
    both_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && consume && !cmd_restart) |=> (pkt_count == $past(pkt_count)));
    // R9
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_restart |=> (pkt_count == '0 && !overflow));
endmodule

// File: tb/sim_vbi_pkt_buffer.sv
`timescale 1ns/1ps
module sim_vbi_pkt_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_sop = 1'b0, rd_strobe = 1'b0;
    logic       cmd_rewind = 1'b0, cmd_next = 1'b0, cmd_restart = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [5:0] pkt_count;
    logic       overflow;
    int         nchk = 0, nerr = 0, cycles = 0;
    bit         done = 1'b0;

    vbi_pkt_buffer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sop(wr_sop), .wr_data(wr_data),
        .rd_strobe(rd_strobe), .cmd_rewind(cmd_rewind), .cmd_next(cmd_next),
        .cmd_restart(cmd_restart), .rd_data(rd_data), .pkt_count(pkt_count),
        .overflow(overflow)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pat(input int tag, input int b);
        return 8'((tag * 11) ^ (b * 37));
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        wr_en = 0; wr_sop = 0; rd_strobe = 0;
        cmd_rewind = 0; cmd_next = 0; cmd_restart = 0;
    endtask

    task automatic clean();
        cmd_restart = 1; tick(); quiet();
    endtask

    task automatic write_pkt(input int tag, input int n);
        for (int b = 0; b < n; b++) begin
            wr_en = 1; wr_sop = (b == 0); wr_data = pat(tag, b);
            tick();
        end
        quiet();
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            rd_strobe = 1; tick();
        end
        quiet();
    endtask

    // Read a full packet, comparing every byte; one check per packet.
    task automatic read_pkt(input string what, input int tag);
        int bad = 0, first_act = 0, first_exp = 0;
        for (int b = 0; b < 44; b++) begin
            if (rd_data != pat(tag, b) && bad == 0) begin
                bad = 1; first_act = rd_data; first_exp = pat(tag, b);
            end
            rd_strobe = 1; tick();
        end
        quiet();
        chk(what, first_act, first_exp);
    endtask

    task automatic t_reset_basic();
        chk("R1 count after reset", pkt_count, 0);
        chk("R1 overflow after reset", overflow, 0);
        write_pkt(1, 44);
        chk("R2 count after one packet", pkt_count, 1);
        chk("R1 first read position", rd_data, pat(1, 0));
        write_pkt(15, 44);
        for (int b = 0; b < 44; b++) begin
            chk($sformatf("R3 byte %0d in order", b), rd_data, pat(1, b));
            rd_strobe = 1; tick(); quiet();
        end
        chk("R7 count after auto-advance", pkt_count, 1);
        chk("R7 next packet shown", rd_data, pat(15, 0));
    endtask

    task automatic t_rewind();
        clean();
        write_pkt(2, 44);
        strobe(5);
        chk("R3 sixth byte", rd_data, pat(2, 5));
        cmd_rewind = 1; tick(); quiet();
        chk("R5 rewind to byte 0", rd_data, pat(2, 0));
        chk("R5 count kept", pkt_count, 1);
    endtask

    task automatic t_next();
        clean();
        write_pkt(2, 44);
        write_pkt(3, 44);
        strobe(3);
        cmd_next = 1; tick(); quiet();
        chk("R6 next shows following packet", rd_data, pat(3, 0));
        chk("R6 count after next", pkt_count, 1);
        cmd_next = 1; tick(); quiet();
        chk("R6 count to zero", pkt_count, 0);
        cmd_next = 1; tick(); quiet();
        chk("R6 empty next keeps count", pkt_count, 0);
        write_pkt(4, 44);
        chk("R6 empty next kept row", rd_data, pat(4, 0));
    endtask

    task automatic t_sop_mid();
        clean();
        write_pkt(5, 10);
        chk("R10 partial not counted", pkt_count, 0);
        write_pkt(6, 44);
        chk("R10 count after restarted packet", pkt_count, 1);
        read_pkt("R10 restarted packet content", 6);
    endtask

    task automatic t_restart();
        clean();
        write_pkt(7, 44);
        write_pkt(8, 5);
        cmd_restart = 1; cmd_next = 1; rd_strobe = 1;
        wr_en = 1; wr_data = pat(8, 5); tick(); quiet();
        chk("R9 count cleared", pkt_count, 0);
        for (int b = 0; b < 44; b++) begin
            wr_en = 1; wr_data = pat(8, b + 5); tick();
        end
        quiet();
        chk("R9 bytes without sop ignored", pkt_count, 0);
        write_pkt(9, 44);
        chk("R9 write at first row", pkt_count, 1);
        chk("R9 read at first row", rd_data, pat(9, 0));
    endtask

    task automatic t_same_cycle();
        clean();
        write_pkt(10, 44);
        write_pkt(11, 44);
        for (int b = 0; b < 44; b++) begin
            wr_en = 1; wr_sop = (b == 0); wr_data = pat(12, b);
            cmd_next = (b == 43);
            tick();
        end
        quiet();
        chk("R11 commit and consume together", pkt_count, 2);
        chk("R11 read moved on", rd_data, pat(11, 0));
        strobe(2);
        rd_strobe = 1; cmd_rewind = 1; tick(); quiet();
        chk("R11 rewind beats step", rd_data, pat(11, 0));
        cmd_next = 1; cmd_rewind = 1; tick(); quiet();
        chk("R11 next beats rewind", rd_data, pat(12, 0));
        chk("R11 count after next", pkt_count, 1);
        for (int b = 0; b < 44; b++) begin
            wr_en = 1; wr_sop = (b == 0); wr_data = pat(13, b);
            cmd_restart = (b == 43);
            tick();
        end
        quiet();
        chk("R11 restart beats commit", pkt_count, 0);
    endtask

    task automatic t_full_wrap();
        clean();
        for (int p = 0; p < 45; p++) write_pkt(20 + p, 44);
        chk("R4 count at full", pkt_count, 45);
        chk("R8 no overflow yet", overflow, 0);
        write_pkt(99, 44);
        chk("R8 count unchanged when full", pkt_count, 45);
        chk("R8 overflow set", overflow, 1);
        for (int p = 0; p < 45; p++) read_pkt($sformatf("R8 packet %0d intact", p), 20 + p);
        chk("R4 all consumed", pkt_count, 0);
        write_pkt(70, 44);
        chk("R4 ring wrap position", rd_data, pat(70, 0));
        chk("R8 overflow sticky", overflow, 1);
        clean();
        chk("R9 overflow cleared", overflow, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        quiet();
        repeat (3) tick();
        rst_n = 1;
        t_reset_basic();
        t_rewind();
        t_next();
        t_sop_mid();
        t_restart();
        t_same_cycle();
        t_full_wrap();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule